// File: doc/BRIEF.md
# Embedded interval, fixed-period and watchdog timer unit

This block holds three timers that all advance on a single time-base tick input. A programmable interval timer counts down from a software-loaded value and can reload itself when it expires. A fixed-period timer expires every power-of-two number of ticks. A watchdog escalates through stages on successive expiries: first a warning, then an interrupt, and finally a reset request whose type comes from the control register.

Software reaches the unit through a small register port. The port selects one of three registers: a control register, a status register and the interval counter. All three are read combinationally. The control register keeps only its ten upper bits. The status register clears bits on write-one, but only inside its six upper bits. Three level interrupt lines and a one-cycle reset request with a 2-bit type are the outputs. Carrying out the reset is left to the surrounding logic. The period exponents are parameters: the base exponent and the step between the four selections.

Top module: `emb_tmr_unit`

## Requirements
- R1: After reset, the control, status and interval-counter reads return 0, all three interrupt lines are low, and the reset request is low. Register select codes are 0 control, 1 status, 2 interval counter, and 3 reads 0.
- R2: The fixed-period timer expires after 2^(FIT_BASE + k*FIT_STEP) ticks, where k is control bits 25:24. Each expiry sets status bit 26, and `fit_irq` is high while status bit 26 and control bit 23 are both 1.
- R3: A write to the interval counter loads both the reload value and the count. The counter decrements once per tick and expires on the tick that takes it from 1 to 0. Each expiry sets status bit 27. `pit_irq` is high while status bit 27 and control bit 26 are both set, unless muted (R8).
- R4: The interval timer runs only while its reload value is greater than 1 and control bit 26 is 1. After an expiry it reloads and continues if control bit 22 is 1, and otherwise it stops at 0.
- R5: Every control write re-evaluates whether the interval timer runs. If the write starts a timer whose count is 0, the count is loaded from the reload value.
- R6: The watchdog period is 2^(WDG_BASE + k*WDG_STEP) ticks, where k is control bits 31:30. On an expiry, status bits 31:30 move as follows: 0 goes to 2, 1 goes to 3, and 2 goes to 3. The move from 2 to 3 sets bit 30. `wdg_irq` is high while status bit 30 and control bit 27 are both 1.
- R7: A watchdog expiry with status bits 31:30 equal to 3 copies control bits 29:28 into status bits 29:28. If that value is nonzero, `rst_req` pulses for one cycle with `rst_kind` equal to it (1 core, 2 chip, 3 system). A value of 0 produces no pulse.
- R8: A status write clears exactly the bits written as 1 within bits 31:26, and bits 25:0 have no effect. A status write with bit 31 set also forces `pit_irq` low until the next interval expiry.
- R9: A control write keeps only bits 31:22 of the written value, and bits 21:0 read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base tick, one count per cycle it is high |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 interval counter |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| pit_irq | output | 1 | Interval timer interrupt level |
| fit_irq | output | 1 | Fixed-period timer interrupt level |
| wdg_irq | output | 1 | Watchdog interrupt level |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 2 | Type of the last reset request |

## Verification
The embedded assertions check several properties on every cycle. They check that a running interval count never exceeds its reload value. They check that a non-reloading expiry stops the timer. They check that each period counter stays inside its longest period. They check that the fixed-period status bit rises only on an expiry. They check that a watchdog expiry from stage 0 with no status write lands in stage 2. They check that a reset request follows only from stage 3. Only the bench scenarios can show the exact periods under different selections, and the masked write-one-to-clear. They also show the interrupt mute and the stop or continue after an interval expiry. Finally they show the reset type reported on each pulse.

// File: rtl/emb_tmr_pkg.sv
package emb_tmr_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_PIT  = 2'd2,
      SEL_NONE = 2'd3
   } tmr_sel_e;

   // control register bit positions
   localparam int CTL_LSB      = 22;
   localparam int CTL_AUTO     = 22;
   localparam int CTL_FIT_EN   = 23;
   localparam int CTL_FIT_PER  = 24;
   localparam int CTL_PIT_EN   = 26;
   localparam int CTL_WDG_EN   = 27;
   localparam int CTL_RST_TYPE = 28;
   localparam int CTL_WDG_PER  = 30;
   // status register bit positions
   localparam int ST_LSB       = 26;
   localparam int ST_FIT       = 26;
   localparam int ST_PIT       = 27;
   localparam int ST_WDG_MUTE  = 31;
endpackage

// File: rtl/emb_tmr_period.sv
module emb_tmr_period #(
   parameter int BASE = 9,
   parameter int STEP = 4,
   localparam int CW  = BASE + 3 * STEP
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] sel,
   output logic       expire
);
   if (BASE < 1 || STEP < 1 || CW > 40) begin : bad_cfg
      $error("emb_tmr_period: BASE and STEP must be >= 1 and the widest period at most 2^40");
   end

   logic [CW-1:0] lim [4];
   logic [CW-1:0] cnt;

   for (genvar k = 0; k < 4; k++) begin : g_lim
      localparam logic [63:0] FULL = (64'd1 << (BASE + k * STEP)) - 64'd1;
      assign lim[k] = FULL[CW-1:0];
   end

   assign expire = tick && (cnt >= lim[sel]);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (expire) cnt <= '0;
      else if (tick)   cnt <= cnt + 1'b1;
   end

   // R2
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim[3]);
endmodule

// File: rtl/emb_tmr_pit.sv
module emb_tmr_pit #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         ctl_upd,
   input  logic         en,
   input  logic         auto_rl,
   output logic [W-1:0] cnt,
   output logic         expire
);
   if (W < 2 || W > 32) begin : bad_cfg
      $error("emb_tmr_pit: W must lie in 2..32");
   end

   logic [W-1:0] reload;
   logic         run;
   logic         can_run;

   assign can_run = (reload > W'(1)) && en;
   assign expire  = tick && run && !ld && !ctl_upd && (cnt <= W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload <= '0;
         cnt    <= '0;
         run    <= 1'b0;
      end else if (ld) begin
         reload <= ld_val;
         cnt    <= ld_val;
         run    <= (ld_val > W'(1)) && en;
      end else if (ctl_upd) begin
         run <= can_run;
         if (can_run && cnt == '0) cnt <= reload;
      end else if (expire) begin
         cnt <= auto_rl ? reload : '0;
         run <= auto_rl;
      end else if (tick && run) begin
         cnt <= cnt - 1'b1;
      end
   end

   // R3
   cnt_le_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= reload));
   // R4
   oneshot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !auto_rl) |=> (!run && cnt == '0));
endmodule

// File: rtl/emb_tmr_unit.sv
module emb_tmr_unit
   import emb_tmr_pkg::*;
#(
   parameter int PIT_W    = 32,
   parameter int FIT_BASE = 9,
   parameter int FIT_STEP = 4,
   parameter int WDG_BASE = 17,
   parameter int WDG_STEP = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        reg_wr,
   input  logic [1:0]  reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        pit_irq,
   output logic        fit_irq,
   output logic        wdg_irq,
   output logic        rst_req,
   output logic [1:0]  rst_kind
);
   localparam int CTL_W = 32 - CTL_LSB;
   localparam int ST_W  = 32 - ST_LSB;

   tmr_sel_e            sel;
   logic [CTL_W-1:0]    ctl_q;
   logic [ST_W-1:0]     st_q;
   logic [ST_W-1:0]     st_d;
   logic [31:0]         ctl, st;
   logic                wr_ctl, wr_st, wr_pit;
   logic                fit_exp, wdg_exp, pit_exp;
   logic                pit_mute;
   logic [PIT_W-1:0]    pit_cnt;
   logic [1:0]          wd_stage;
   logic                pit_en_next;

   assign sel    = tmr_sel_e'(reg_sel);
   assign wr_ctl = reg_wr && sel == SEL_CTRL;
   assign wr_st  = reg_wr && sel == SEL_STAT;
   assign wr_pit = reg_wr && sel == SEL_PIT;
   assign ctl    = {ctl_q, {CTL_LSB{1'b0}}};
   assign st     = {st_q, {ST_LSB{1'b0}}};
   assign wd_stage = st[31:30];
   assign pit_en_next = wr_ctl ? reg_wdata[CTL_PIT_EN] : ctl[CTL_PIT_EN];

   emb_tmr_period #(.BASE(FIT_BASE), .STEP(FIT_STEP)) u_fit (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .sel(ctl[CTL_FIT_PER +: 2]), .expire(fit_exp));

   emb_tmr_period #(.BASE(WDG_BASE), .STEP(WDG_STEP)) u_wdg (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .sel(ctl[CTL_WDG_PER +: 2]), .expire(wdg_exp));

   emb_tmr_pit #(.W(PIT_W)) u_pit (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .ld(wr_pit), .ld_val(reg_wdata[PIT_W-1:0]),
      .ctl_upd(wr_ctl), .en(pit_en_next), .auto_rl(ctl[CTL_AUTO]),
      .cnt(pit_cnt), .expire(pit_exp));

   // status next state: clear written ones, then apply hardware events
   always_comb begin
      st_d = st_q;
      if (wr_st) st_d = st_q & ~reg_wdata[31:ST_LSB];
      if (fit_exp) st_d[ST_FIT - ST_LSB] = 1'b1;
      if (pit_exp) st_d[ST_PIT - ST_LSB] = 1'b1;
      if (wdg_exp) begin
         case (wd_stage)
            2'd0, 2'd1: st_d[ST_W-1] = 1'b1;
            2'd2:       st_d[ST_W-2] = 1'b1;
            default:    st_d[CTL_RST_TYPE - ST_LSB +: 2] = ctl[CTL_RST_TYPE +: 2];
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q    <= '0;
         st_q     <= '0;
         pit_mute <= 1'b0;
         rst_req  <= 1'b0;
         rst_kind <= 2'd0;
      end else begin
         if (wr_ctl) ctl_q <= reg_wdata[31:CTL_LSB];
         st_q <= st_d;
         if (pit_exp)                           pit_mute <= 1'b0;
         else if (wr_st && reg_wdata[ST_WDG_MUTE]) pit_mute <= 1'b1;
         rst_req <= wdg_exp && wd_stage == 2'd3 && ctl[CTL_RST_TYPE +: 2] != 2'd0;
         if (wdg_exp && wd_stage == 2'd3 && ctl[CTL_RST_TYPE +: 2] != 2'd0)
            rst_kind <= ctl[CTL_RST_TYPE +: 2];
      end
   end

   always_comb begin
      case (sel)
         SEL_CTRL: reg_rdata = ctl;
         SEL_STAT: reg_rdata = st;
         SEL_PIT:  reg_rdata = 32'(pit_cnt);
         default:  reg_rdata = '0;
      endcase
   end

   assign fit_irq = st[ST_FIT] && ctl[CTL_FIT_EN];
   assign pit_irq = st[ST_PIT] && ctl[CTL_PIT_EN] && !pit_mute;
   assign wdg_irq = st[30] && ctl[CTL_WDG_EN];

   // R2
   fit_rise_on_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st[ST_FIT]) |-> $past(fit_exp));
   // R6
   wdg_first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wdg_exp && wd_stage == 2'd0 && !wr_st) |=> (wd_stage == 2'd2));
   // R7
   rst_from_last_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ($past(wd_stage) == 2'd3 && $past(wdg_exp)));
endmodule

// File: tb/emb_tmr_unit_bench.sv
module emb_tmr_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pit_irq, fit_irq, wdg_irq, rst_req;
   logic [1:0]  rst_kind;

   int nchk = 0;
   int nfail = 0;
   logic [1:0] rst_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   emb_tmr_unit #(.PIT_W(32), .FIT_BASE(2), .FIT_STEP(1),
                  .WDG_BASE(3), .WDG_STEP(1)) u_emb_tmr_unit (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pit_irq(pit_irq), .fit_irq(fit_irq), .wdg_irq(wdg_irq),
      .rst_req(rst_req), .rst_kind(rst_kind));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: every reset pulse is matched against the expected queue (R7)
   always @(negedge clk) begin
      if (rst_n && rst_req) begin
         if (rst_q.size() == 0) chk("R7 unexpected reset pulse", 32'(rst_kind), 32'hx);
         else chk("R7 reset kind", 32'(rst_kind), 32'(rst_q.pop_front()));
      end
   end

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; tick = 1'b0; reg_wr = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic wr(logic [1:0] s, logic [31:0] d);
      @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1 reg_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] s, logic [31:0] mask, logic [31:0] exp, string tag);
      @(negedge clk); reg_sel = s; #1;
      chk(tag, reg_rdata & mask, exp);
   endtask

   task automatic ticks(int n);
      @(negedge clk); tick = 1'b1;
      repeat (n) @(posedge clk);
      #1 tick = 1'b0;
   endtask

   task automatic outs(logic [2:0] exp, string tag);
      @(negedge clk);
      chk(tag, {29'd0, pit_irq, fit_irq, wdg_irq}, {29'd0, exp});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      nfail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      // ---- R1 reset state
      do_reset();
      rd(2'd0, '1, 32'h0, "R1 control");
      rd(2'd1, '1, 32'h0, "R1 status");
      rd(2'd2, '1, 32'h0, "R1 counter");
      rd(2'd3, '1, 32'h0, "R1 unused select");
      outs(3'b000, "R1 irq lines");
      chk("R1 rst_req", 32'(rst_req), 32'h0);

      // ---- R2 fixed-period timer, period 4 then 8
      wr(2'd0, 32'h0080_0000);
      ticks(3);
      rd(2'd1, 32'h0400_0000, 32'h0, "R2 before first expiry");
      ticks(1);
      rd(2'd1, 32'h0400_0000, 32'h0400_0000, "R2 expiry after 4 ticks");
      outs(3'b010, "R2 fit_irq high");
      // R8 writes outside the mask leave the bit alone
      wr(2'd1, 32'h03FF_FFFF);
      rd(2'd1, 32'h0400_0000, 32'h0400_0000, "R8 low bits ignored");
      wr(2'd1, 32'h0400_0000);
      rd(2'd1, 32'h0400_0000, 32'h0, "R8 clear bit26");
      outs(3'b000, "R2 fit_irq low after clear");
      wr(2'd0, 32'h0180_0000);
      ticks(7);
      rd(2'd1, 32'h0400_0000, 32'h0, "R2 period 8 not yet");
      ticks(1);
      rd(2'd1, 32'h0400_0000, 32'h0400_0000, "R2 period 8 expiry");
      // R9 control keeps only upper bits
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, '1, 32'hFFC0_0000, "R9 control readback");

      // ---- R3 R4 R5 R8 interval timer
      do_reset();
      wr(2'd0, 32'h0440_0000);
      wr(2'd2, 32'd5);
      rd(2'd2, '1, 32'd5, "R3 load count");
      ticks(4);
      rd(2'd2, '1, 32'd1, "R3 count after 4 ticks");
      rd(2'd1, 32'h0800_0000, 32'h0, "R3 no expiry yet");
      ticks(1);
      rd(2'd1, 32'h0800_0000, 32'h0800_0000, "R3 expiry sets bit27");
      outs(3'b100, "R3 pit_irq high");
      rd(2'd2, '1, 32'd5, "R4 auto reload");
      wr(2'd1, 32'h0800_0000);
      outs(3'b000, "R3 pit_irq low after clear");
      ticks(5);
      rd(2'd1, 32'h0800_0000, 32'h0800_0000, "R4 second period");
      wr(2'd1, 32'h8000_0000);
      rd(2'd1, 32'h0800_0000, 32'h0800_0000, "R8 bit31 write keeps bit27");
      outs(3'b000, "R8 bit31 write mutes pit_irq");
      wr(2'd0, 32'h0400_0000);
      wr(2'd1, 32'h0800_0000);
      ticks(5);
      rd(2'd1, 32'h0800_0000, 32'h0800_0000, "R4 one-shot expiry");
      outs(3'b100, "R8 mute released by expiry");
      rd(2'd2, '1, 32'd0, "R4 stopped at zero");
      wr(2'd1, 32'h0800_0000);
      ticks(6);
      rd(2'd1, 32'h0800_0000, 32'h0, "R4 no expiry after stop");
      wr(2'd2, 32'd1);
      ticks(3);
      rd(2'd2, '1, 32'd1, "R4 reload of 1 does not run");
      wr(2'd0, 32'h0040_0000);
      wr(2'd2, 32'd4);
      ticks(6);
      rd(2'd2, '1, 32'd4, "R4 disabled does not run");
      wr(2'd0, 32'h0440_0000);
      ticks(3);
      rd(2'd2, '1, 32'd1, "R5 control write starts timer");
      ticks(1);
      rd(2'd1, 32'h0800_0000, 32'h0800_0000, "R5 expiry after restart");

      // ---- R6 R7 watchdog, period 8, chip reset type
      do_reset();
      wr(2'd0, 32'h2800_0000);
      ticks(8);
      rd(2'd1, 32'hF000_0000, 32'h8000_0000, "R6 stage 0 to 2");
      outs(3'b000, "R6 wdg_irq low in stage 2");
      ticks(8);
      rd(2'd1, 32'hF000_0000, 32'hC000_0000, "R6 stage 2 to 3");
      outs(3'b001, "R6 wdg_irq high");
      rst_q.push_back(2'd2);
      ticks(8);
      rd(2'd1, 32'hF000_0000, 32'hE000_0000, "R7 type copied");
      chk("R7 pulse seen", 32'(rst_q.size()), 32'd0);
      wr(2'd1, 32'h8000_0000);
      rd(2'd1, 32'hC000_0000, 32'h4000_0000, "R8 clear bit31 only");
      ticks(8);
      rd(2'd1, 32'hC000_0000, 32'hC000_0000, "R6 stage 1 to 3");
      wr(2'd0, 32'h4000_0000);
      wr(2'd1, 32'hC000_0000);
      ticks(15);
      rd(2'd1, 32'hC000_0000, 32'h0, "R6 period 16 not yet");
      ticks(1);
      rd(2'd1, 32'hC000_0000, 32'h8000_0000, "R6 period 16 expiry");
      // type 0 at stage 3 gives no pulse
      ticks(16);
      ticks(16);
      rd(2'd1, 32'h3000_0000, 32'h0, "R7 type 0 copied");
      chk("R7 no pulse for type 0", 32'(rst_q.size()), 32'd0);

      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule